// File: doc/BRIEF.md
# Light-Sensing DRAM Capture Controller

This block drives a 64k-bit dynamic RAM whose cells are exposed to light, so the array works as a binary image sensor. It puts multiplexed row and column addresses on a shared 8-bit bus and controls active-low row strobe, column strobe and write enable. It drives the write data bit and samples the read data bit. While it waits for a request, it keeps the image rows alive with regular bursts of refresh cycles that strobe only the row.

A capture request starts a fixed sequence. The controller first writes a one into every image cell. It then stops all row activity for an exposure time. This time is a count of clock cycles, taken from an input when the capture is accepted. During the exposure, light drains the charge of the lit cells. The controller then reads every cell back and streams each pixel out with its row and column. A cell that has lost its one is reported as lit. Refresh restarts when the exposure ends, and refresh bursts are placed between pixel accesses.

The image size, the refresh period and the three strobe timing minimums are parameters.

Top module: `optic_sense_ctrl`

## Requirements
- R1: Each access presents the row address while the row strobe is high, then drives the row strobe low, then presents the column address, then drives the column strobe low. The column strobe is only ever low while the row strobe is low. All three control strobes (`rasN`, `casN`, `weN`) are active low.
- R2: Before every falling edge of the row strobe, the row strobe has been high for at least T_RP cycles. From the row strobe falling to the column strobe falling is at least T_RCD cycles. The column strobe stays low for at least T_CAS cycles.
- R3: Every REFRESH_CYCLES clock cycles, a burst of row-only cycles visits rows 0 to IMG_ROWS-1 in ascending order, with no column strobe. While no capture is running, consecutive bursts start exactly REFRESH_CYCLES cycles apart.
- R4: A one-cycle `captureReq` pulse while `busy` is low starts a capture. If the pulse arrives during a refresh burst, the capture starts only after the burst's remaining rows are done. A pulse while `busy` is high is ignored.
- R5: In each capture, the fill step writes `din`=1 with `weN` low into each of the IMG_ROWS x IMG_COLS cells exactly once.
- R6: After the fill, the row strobe stays high for at least the number of cycles that `exposeCycles` held when the capture was accepted.
- R7: Readout gives one pixel per read, with `pixValid` high for one cycle and `pixRow`/`pixCol` carrying its coordinates. Pixels come in row-major order: the column runs from 0 to IMG_COLS-1 within each row, and rows go from 0 upward.
- R8: `pixLit` is 1 when the cell read back 0 (the cell was illuminated) and 0 when it read back 1.
- R9: `busy` rises when a capture is accepted and stays high through `frameDone`. `frameDone` is a single-cycle pulse that comes exactly one cycle after the last `pixValid`. `busy` is low in the following cycle.
- R10: Under reset, `rasN`, `casN` and `weN` are high, and `busy`, `pixValid` and `frameDone` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| captureReq | input | 1 | One-cycle capture request |
| exposeCycles | input | EXP_W | Exposure length in clock cycles, taken when the capture is accepted |
| addr | output | ADDR_W | Multiplexed row/column address |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| din | output | 1 | Bit written into the selected cell |
| dout | input | 1 | Bit read from the selected cell |
| busy | output | 1 | Capture in progress |
| frameDone | output | 1 | Pulse after the last pixel |
| pixValid | output | 1 | Pixel output valid |
| pixLit | output | 1 | 1 when the pixel was illuminated |
| pixRow | output | clog2(IMG_ROWS) | Row of the current pixel |
| pixCol | output | clog2(IMG_COLS) | Column of the current pixel |

## Verification
Some properties are checked on every cycle by assertions:
- the column strobe is low only inside a low row strobe;
- the three strobe timing minimums hold;
- writes, and pixels, appear only while a capture is busy;
- `frameDone` is a single pulse that closes `busy`.

Other behaviours need a light-sensitive memory model in the bench and can only be shown by its scenarios:
- the exposure really suspends refresh long enough for lit cells to decay;
- a short exposure leaves every pixel dark;
- refresh bursts keep their period and row order;
- a request during a burst is deferred;
- a request during a capture is dropped.

// File: rtl/optic_sense_pkg.sv
package optic_sense_pkg;

  typedef enum logic [1:0] {
    OP_REFRESH,
    OP_WRITE,
    OP_READ
  } accOp_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRECHG,
    ST_ROWSET,
    ST_RASHOLD,
    ST_COLSET,
    ST_CASHOLD,
    ST_RELEASE
  } accState_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FILL,
    PH_EXPOSE,
    PH_READOUT,
    PH_DONE
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadExp;
    logic expTick;
    logic refAck;
    logic refRowClear;
    logic refRowStep;
    logic posClear;
    logic posStep;
    logic useRefRow;
    logic useCol;
    logic sample;
  } dpStrobe_t;

endpackage

// File: rtl/optic_sense_datapath.sv
module optic_sense_datapath
  import optic_sense_pkg::*;
#(
  parameter int IMG_ROWS       = 128,
  parameter int IMG_COLS       = 256,
  parameter int ADDR_W         = 8,
  parameter int EXP_W          = 24,
  parameter int REFRESH_CYCLES = 130000
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   stb,
  input  logic [EXP_W-1:0]            exposeCycles,
  input  logic                        dout,
  output logic [ADDR_W-1:0]           addr,
  output logic                        refPending,
  output logic                        expDone,
  output logic                        posLast,
  output logic                        refRowLast,
  output logic                        pixValid,
  output logic                        pixLit,
  output logic [$clog2(IMG_ROWS)-1:0] pixRow,
  output logic [$clog2(IMG_COLS)-1:0] pixCol
);

  localparam int ROW_W = $clog2(IMG_ROWS);
  localparam int COL_W = $clog2(IMG_COLS);
  localparam int REF_W = $clog2(REFRESH_CYCLES);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(IMG_ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(IMG_COLS - 1);
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(REFRESH_CYCLES - 1);

  logic [REF_W-1:0] refTimer;
  logic [EXP_W-1:0] expCnt;
  logic [ROW_W-1:0] refRow;
  logic [ROW_W-1:0] rowCnt;
  logic [COL_W-1:0] colCnt;
  logic             refTick;

  assign refTick = (refTimer == REF_LAST);

  // free-running refresh period timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refTimer   <= '0;
      refPending <= 1'b0;
    end else begin
      refTimer <= refTick ? '0 : refTimer + REF_W'(1);
      if (refTick)
        refPending <= 1'b1;
      else if (stb.refAck)
        refPending <= 1'b0;
    end
  end

  // exposure down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      expCnt <= '0;
    else if (stb.loadExp)
      expCnt <= exposeCycles;
    else if (stb.expTick && expCnt != '0)
      expCnt <= expCnt - EXP_W'(1);
  end
  assign expDone = (expCnt == '0);

  // refresh row pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      refRow <= '0;
    else if (stb.refRowClear)
      refRow <= '0;
    else if (stb.refRowStep)
      refRow <= refRow + ROW_W'(1);
  end
  assign refRowLast = (refRow == ROW_LAST);

  // pixel position, column fastest
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowCnt <= '0;
      colCnt <= '0;
    end else if (stb.posClear) begin
      rowCnt <= '0;
      colCnt <= '0;
    end else if (stb.posStep) begin
      if (colCnt == COL_LAST) begin
        colCnt <= '0;
        rowCnt <= rowCnt + ROW_W'(1);
      end else begin
        colCnt <= colCnt + COL_W'(1);
      end
    end
  end
  assign posLast = (rowCnt == ROW_LAST) && (colCnt == COL_LAST);

  // shared address bus
  always_comb begin
    if (stb.useCol)
      addr = ADDR_W'(colCnt);
    else if (stb.useRefRow)
      addr = ADDR_W'(refRow);
    else
      addr = ADDR_W'(rowCnt);
  end

  // pixel output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixValid <= 1'b0;
      pixLit   <= 1'b0;
      pixRow   <= '0;
      pixCol   <= '0;
    end else begin
      pixValid <= stb.sample;
      if (stb.sample) begin
        pixLit <= ~dout;
        pixRow <= rowCnt;
        pixCol <= colCnt;
      end
    end
  end

endmodule

// File: rtl/optic_sense_control.sv
module optic_sense_control
  import optic_sense_pkg::*;
#(
  parameter int T_RP  = 2,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      captureReq,
  input  logic      refPending,
  input  logic      expDone,
  input  logic      posLast,
  input  logic      refRowLast,
  output dpStrobe_t stb,
  output logic      rasN,
  output logic      casN,
  output logic      weN,
  output logic      din,
  output logic      busy,
  output logic      frameDone
);

  localparam int WAIT_W = $clog2(T_RP + T_RCD + T_CAS + 1);
  localparam logic [WAIT_W-1:0] W_PRE   = WAIT_W'(T_RP - 1);
  localparam logic [WAIT_W-1:0] W_RCD   = WAIT_W'(T_RCD - 1);
  localparam logic [WAIT_W-1:0] W_REFHD = WAIT_W'(T_RCD + T_CAS - 1);
  localparam logic [WAIT_W-1:0] W_CAS   = WAIT_W'(T_CAS - 1);

  phase_t            phase, phaseNext;
  accState_t         accState, accNext;
  accOp_t            curOp, opNext;
  logic [WAIT_W-1:0] waitCnt, waitNext;
  logic              capPending, capNext;
  logic              waitZero;

  assign waitZero = (waitCnt == '0);

  always_comb begin
    phaseNext = phase;
    accNext   = accState;
    opNext    = curOp;
    waitNext  = waitCnt;
    capNext   = capPending;
    stb       = '0;
    stb.useRefRow = (curOp == OP_REFRESH);
    stb.useCol    = accState inside {ST_COLSET, ST_CASHOLD, ST_RELEASE};

    if (captureReq && phase == PH_IDLE)
      capNext = 1'b1;

    if (phase == PH_EXPOSE) begin
      if (expDone) begin
        phaseNext    = PH_READOUT;
        stb.posClear = 1'b1;
      end else begin
        stb.expTick = 1'b1;
      end
    end
    if (phase == PH_DONE)
      phaseNext = PH_IDLE;

    unique case (accState)
      ST_IDLE: begin
        if (refPending && phase != PH_EXPOSE) begin
          stb.refAck      = 1'b1;
          stb.refRowClear = 1'b1;
          opNext          = OP_REFRESH;
          accNext         = ST_PRECHG;
          waitNext        = W_PRE;
        end else if (phase == PH_IDLE && capPending) begin
          phaseNext    = PH_FILL;
          capNext      = 1'b0;
          stb.loadExp  = 1'b1;
          stb.posClear = 1'b1;
        end else if (phase == PH_FILL) begin
          opNext   = OP_WRITE;
          accNext  = ST_PRECHG;
          waitNext = W_PRE;
        end else if (phase == PH_READOUT) begin
          opNext   = OP_READ;
          accNext  = ST_PRECHG;
          waitNext = W_PRE;
        end
      end
      ST_PRECHG: begin
        if (waitZero) accNext = ST_ROWSET;
        else          waitNext = waitCnt - WAIT_W'(1);
      end
      ST_ROWSET: begin
        accNext  = ST_RASHOLD;
        waitNext = (curOp == OP_REFRESH) ? W_REFHD : W_RCD;
      end
      ST_RASHOLD: begin
        if (waitZero) accNext = (curOp == OP_REFRESH) ? ST_RELEASE : ST_COLSET;
        else          waitNext = waitCnt - WAIT_W'(1);
      end
      ST_COLSET: begin
        accNext  = ST_CASHOLD;
        waitNext = W_CAS;
      end
      ST_CASHOLD: begin
        if (waitZero) begin
          stb.sample = (curOp == OP_READ);
          accNext    = ST_RELEASE;
        end else begin
          waitNext = waitCnt - WAIT_W'(1);
        end
      end
      ST_RELEASE: begin
        if (curOp == OP_REFRESH) begin
          if (refRowLast) begin
            accNext = ST_IDLE;
          end else begin
            stb.refRowStep = 1'b1;
            accNext        = ST_PRECHG;
            waitNext       = W_PRE;
          end
        end else begin
          stb.posStep = 1'b1;
          accNext     = ST_IDLE;
          if (posLast)
            phaseNext = (curOp == OP_WRITE) ? PH_EXPOSE : PH_DONE;
        end
      end
      default: accNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      accState   <= ST_IDLE;
      curOp      <= OP_REFRESH;
      waitCnt    <= '0;
      capPending <= 1'b0;
    end else begin
      phase      <= phaseNext;
      accState   <= accNext;
      curOp      <= opNext;
      waitCnt    <= waitNext;
      capPending <= capNext;
    end
  end

  // pin decode straight from state registers
  always_comb begin
    rasN      = !(accState inside {ST_RASHOLD, ST_COLSET, ST_CASHOLD});
    casN      = (accState != ST_CASHOLD);
    din       = (curOp == OP_WRITE) && (accState inside {ST_COLSET, ST_CASHOLD});
    weN       = !din;
    busy      = (phase != PH_IDLE);
    frameDone = (phase == PH_DONE);
  end

endmodule

// File: rtl/optic_sense_ctrl.sv
module optic_sense_ctrl
  import optic_sense_pkg::*;
#(
  parameter int IMG_ROWS       = 128,
  parameter int IMG_COLS       = 256,
  parameter int ADDR_W         = 8,
  parameter int EXP_W          = 24,
  parameter int REFRESH_CYCLES = 130000,
  parameter int T_RP           = 2,
  parameter int T_RCD          = 2,
  parameter int T_CAS          = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        captureReq,
  input  logic [EXP_W-1:0]            exposeCycles,
  output logic [ADDR_W-1:0]           addr,
  output logic                        rasN,
  output logic                        casN,
  output logic                        weN,
  output logic                        din,
  input  logic                        dout,
  output logic                        busy,
  output logic                        frameDone,
  output logic                        pixValid,
  output logic                        pixLit,
  output logic [$clog2(IMG_ROWS)-1:0] pixRow,
  output logic [$clog2(IMG_COLS)-1:0] pixCol
);

  dpStrobe_t stb;
  logic      refPending;
  logic      expDone;
  logic      posLast;
  logic      refRowLast;

  optic_sense_control #(
    .T_RP (T_RP),
    .T_RCD(T_RCD),
    .T_CAS(T_CAS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .captureReq(captureReq),
    .refPending(refPending),
    .expDone   (expDone),
    .posLast   (posLast),
    .refRowLast(refRowLast),
    .stb       (stb),
    .rasN      (rasN),
    .casN      (casN),
    .weN       (weN),
    .din       (din),
    .busy      (busy),
    .frameDone (frameDone)
  );

  optic_sense_datapath #(
    .IMG_ROWS      (IMG_ROWS),
    .IMG_COLS      (IMG_COLS),
    .ADDR_W        (ADDR_W),
    .EXP_W         (EXP_W),
    .REFRESH_CYCLES(REFRESH_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .exposeCycles(exposeCycles),
    .dout        (dout),
    .addr        (addr),
    .refPending  (refPending),
    .expDone     (expDone),
    .posLast     (posLast),
    .refRowLast  (refRowLast),
    .pixValid    (pixValid),
    .pixLit      (pixLit),
    .pixRow      (pixRow),
    .pixCol      (pixCol)
  );

endmodule

// File: rtl/optic_sense_checker.sv
module optic_sense_checker #(
  parameter int T_RP  = 2,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2
) (
  input logic clk,
  input logic rstN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic din,
  input logic busy,
  input logic frameDone,
  input logic pixValid
);

  logic [7:0] preRun;
  logic [7:0] rcdRun;
  logic [7:0] casRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preRun <= '0;
      rcdRun <= '0;
      casRun <= '0;
    end else begin
      if (!rasN)                  preRun <= '0;
      else if (preRun != 8'hFF)   preRun <= preRun + 8'd1;
      if (rasN)                   rcdRun <= '0;
      else if (casN && rcdRun != 8'hFF) rcdRun <= rcdRun + 8'd1;
      if (casN)                   casRun <= '0;
      else if (casRun != 8'hFF)   casRun <= casRun + 8'd1;
    end
  end

  p_cas_inside_ras_r1: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !rasN);

  p_precharge_min_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (preRun >= 8'(T_RP)));

  p_ras_to_cas_min_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> (rcdRun >= 8'(T_RCD)));

  p_cas_width_min_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(casN) |-> (casRun >= 8'(T_CAS)));

  p_write_ones_in_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> (busy && din));

  p_pixel_in_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> busy);

  p_done_while_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> busy);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  p_busy_ends_at_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(frameDone));

endmodule

bind optic_sense_ctrl optic_sense_checker #(
  .T_RP (T_RP),
  .T_RCD(T_RCD),
  .T_CAS(T_CAS)
) u_check (
  .clk      (clk),
  .rstN     (rstN),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .din      (din),
  .busy     (busy),
  .frameDone(frameDone),
  .pixValid (pixValid)
);

// File: tb/optic_sense_ctrl_test.sv
`timescale 1ns/1ps
module optic_sense_ctrl_test;

  localparam int ROWS  = 4;
  localparam int COLS  = 8;
  localparam int REF   = 200;
  localparam int TRP   = 2;
  localparam int TRCD  = 2;
  localparam int TCAS  = 3;
  localparam int EXPW  = 16;
  localparam int DECAY = 800;
  localparam int NPIX  = ROWS * COLS;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            captureReq = 1'b0;
  logic [EXPW-1:0] exposeCycles = '0;
  logic [7:0]      addr;
  logic            rasN, casN, weN, din;
  logic            doutR = 1'b0;
  logic            busy, frameDone, pixValid, pixLit;
  logic [1:0]      pixRow;
  logic [2:0]      pixCol;

  always #5 clk = ~clk;

  optic_sense_ctrl #(
    .IMG_ROWS(ROWS), .IMG_COLS(COLS), .ADDR_W(8), .EXP_W(EXPW),
    .REFRESH_CYCLES(REF), .T_RP(TRP), .T_RCD(TRCD), .T_CAS(TCAS)
  ) uut (
    .clk(clk), .rstN(rstN), .captureReq(captureReq), .exposeCycles(exposeCycles),
    .addr(addr), .rasN(rasN), .casN(casN), .weN(weN), .din(din), .dout(doutR),
    .busy(busy), .frameDone(frameDone), .pixValid(pixValid), .pixLit(pixLit),
    .pixRow(pixRow), .pixCol(pixCol)
  );

  int checks = 0;
  int errors = 0;

  // light-sensitive memory model and port monitor
  logic [255:0] memRow [0:255];
  int  lastOpen [0:255];
  int  cyc = 0;
  int  pattern = 0;
  bit  expectDecay = 0;
  logic prevRas = 1'b1, prevCas = 1'b1, prevBusy = 1'b0;
  int  curRow = 0;
  int  rasLogRow [0:4095];
  int  rasLogTime [0:4095];
  int  rasLogN = 0;
  int  casFalls = 0, casNoRas = 0;
  int  wrCount = 0, dinBad = 0;
  int  pixCnt = 0, pixOrdBad = 0, pixDataBad = 0, lastPixCyc = 0;
  int  doneCount = 0, doneCyc = 0, busyRises = 0;
  int  runHi = 1000, rcdRun = 0, casRun = 0;
  int  minPre = 1000, minRcd = 1000, minCas = 1000;
  int  busyDark = 0, maxBusyDark = 0;

  function automatic bit litAt(int r, int c);
    if (pattern == 0) return ((r + c) % 3) == 0;
    return (c >= COLS / 2) && (r != 1);
  endfunction

  initial begin
    for (int r = 0; r < 256; r++) begin
      memRow[r] = '0;
      lastOpen[r] = 0;
    end
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rstN) begin
      if (prevRas && !rasN) begin
        curRow = int'(addr);
        for (int c = 0; c < COLS; c++)
          if (litAt(curRow, c) && (cyc - lastOpen[curRow] > DECAY)) memRow[curRow][c] = 1'b0;
        lastOpen[curRow] = cyc;
        if (rasLogN < 4096) begin
          rasLogRow[rasLogN] = curRow;
          rasLogTime[rasLogN] = cyc;
          rasLogN = rasLogN + 1;
        end
        if (runHi < minPre) minPre = runHi;
        rcdRun = 0;
      end
      if (prevCas && !casN) begin
        casFalls = casFalls + 1;
        if (rasN) casNoRas = casNoRas + 1;
        if (rcdRun < minRcd) minRcd = rcdRun;
        if (!weN) begin
          memRow[curRow][addr] = din;
          wrCount = wrCount + 1;
          if (!din) dinBad = dinBad + 1;
        end else begin
          doutR = memRow[curRow][addr];
        end
      end
      if (!prevCas && casN && casRun < minCas) minCas = casRun;
      runHi  = rasN ? runHi + 1 : 0;
      if (!rasN && casN) rcdRun = rcdRun + 1;
      casRun = !casN ? casRun + 1 : 0;
      if (busy && rasN) begin
        busyDark = busyDark + 1;
        if (busyDark > maxBusyDark) maxBusyDark = busyDark;
      end else busyDark = 0;
      if (pixValid) begin
        if (int'(pixRow) != pixCnt / COLS || int'(pixCol) != pixCnt % COLS) pixOrdBad = pixOrdBad + 1;
        if (pixLit != (expectDecay ? litAt(int'(pixRow), int'(pixCol)) : 1'b0)) pixDataBad = pixDataBad + 1;
        pixCnt = pixCnt + 1;
        lastPixCyc = cyc;
      end
      if (frameDone) begin
        doneCount = doneCount + 1;
        doneCyc = cyc;
      end
      if (busy && !prevBusy) busyRises = busyRises + 1;
    end
    prevRas = rasN;
    prevCas = casN;
    prevBusy = busy;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk) captureReq = 1'b1;
    @(negedge clk) captureReq = 1'b0;
  endtask

  task automatic frame_begin(input int exp, input int pat, input bit decay);
    pattern = pat;
    expectDecay = decay;
    exposeCycles = EXPW'(exp);
    pixCnt = 0; pixOrdBad = 0; pixDataBad = 0;
    wrCount = 0; dinBad = 0; doneCount = 0; busyRises = 0; maxBusyDark = 0;
  endtask

  task automatic frame_finish(input int exp, input string name);
    int waited = 0;
    while (doneCount == 0 && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    repeat (3) @(negedge clk);
    check(doneCount == 1, {name, " R9 frameDone count"}, doneCount, 1);
    check(wrCount == NPIX && dinBad == 0, {name, " R5 writes of one"}, wrCount, NPIX);
    check(maxBusyDark >= exp, {name, " R6 dark window"}, maxBusyDark, exp);
    check(pixCnt == NPIX, {name, " R7 pixel count"}, pixCnt, NPIX);
    check(pixOrdBad == 0, {name, " R7 pixel order"}, pixOrdBad, 0);
    check(pixDataBad == 0, {name, " R8 pixel values"}, pixDataBad, 0);
    check(doneCyc - lastPixCyc == 1, {name, " R9 done after last pixel"}, doneCyc - lastPixCyc, 1);
    check(busy == 1'b0, {name, " R9 busy cleared"}, int'(busy), 0);
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    check(rasN && casN && weN, "R10 strobes idle in reset", int'({rasN, casN, weN}), 7);
    check(!busy && !pixValid && !frameDone, "R10 status low in reset",
          int'({busy, pixValid, frameDone}), 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_refresh();
    int startN = rasLogN;
    int startCas = casFalls;
    int ordBad = 0, gapBad = 0, n;
    repeat (700) @(negedge clk);
    n = ((rasLogN - startN) / 4) * 4;
    for (int i = 0; i < n; i++)
      if (rasLogRow[startN + i] != i % 4) ordBad++;
    for (int i = 4; i < n; i += 4)
      if (rasLogTime[startN + i] - rasLogTime[startN + i - 4] != REF) gapBad++;
    check(n >= 12, "R3 refresh bursts seen", n, 12);
    check(ordBad == 0, "R3 refresh row order", ordBad, 0);
    check(gapBad == 0, "R3 refresh period", gapBad, 0);
    check(casFalls == startCas, "R3 refresh is row-only", casFalls - startCas, 0);
  endtask

  task automatic t_long_exposure(input int pat);
    frame_begin(1500, pat, 1'b1);
    pulse_req();
    frame_finish(1500, pat == 0 ? "long exposure A" : "long exposure B");
  endtask

  task automatic t_short_exposure();
    frame_begin(30, 0, 1'b0);
    pulse_req();
    frame_finish(30, "short exposure");
  endtask

  task automatic t_busy_ignored();
    int waited = 0;
    frame_begin(1500, 1, 1'b1);
    pulse_req();
    while (pixCnt < 6 && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    pulse_req();
    frame_finish(1500, "request while busy");
    repeat (3000) @(negedge clk);
    check(busyRises == 1, "R4 request while busy ignored", busyRises, 1);
  endtask

  task automatic t_held_capture();
    int lowCycles = 0, falls = 0, guard = 0;
    logic pr;
    while (!(!rasN && casN && addr == 8'd0 && !busy) && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    frame_begin(1500, 0, 1'b1);
    captureReq = 1'b1;
    pr = rasN;
    @(negedge clk) captureReq = 1'b0;
    while (!busy && lowCycles < 200) begin
      if (pr && !rasN) falls++;
      pr = rasN;
      lowCycles++;
      @(negedge clk);
    end
    check(lowCycles >= 10, "R4 capture held during burst", lowCycles, 10);
    check(falls == ROWS - 1, "R4 burst finished before capture", falls, ROWS - 1);
    frame_finish(1500, "held capture");
  endtask

  task automatic t_timing();
    check(minPre >= TRP, "R2 precharge minimum", minPre, TRP);
    check(minRcd >= TRCD, "R2 row-to-column minimum", minRcd, TRCD);
    check(minCas >= TCAS, "R2 column strobe width", minCas, TCAS);
    check(casNoRas == 0, "R1 column strobe inside row strobe", casNoRas, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_refresh();
        t_long_exposure(0);
        t_short_exposure();
        t_long_exposure(1);
        t_busy_ignored();
        t_held_capture();
        t_timing();
      end
      begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule